// File: doc/BRIEF.md
# Buffered-update PWM channel

This block is one pulse-width-modulated output channel controlled through a small register bus. A power-of-two prescaler slows the input clock. A period counter runs at the slowed rate. The output sits at its inactive level while the counter is below the duty value, and it is active for the rest of the period. A polarity bit picks which output level counts as active.

While the channel is stopped, software writes the period and duty values directly. While it runs, those direct writes are locked out. Software instead writes a single shared update register. A target bit in the mode register decides whether that value replaces the duty or the period. The value waits as a pending change until the counter wraps, so the output never shows a half-applied setting inside a period. When the change lands, a sticky status flag is raised. Software polls the flag, and reading it clears it.

Top module: `pwm_buf_chan`

## Requirements
- R1: After reset the channel is disabled, the output is 0, the mode register reads 0x200 (prescale 0, polarity 1, update target 0), and period, duty, enable and status all read 0.
- R2: Register addresses: 0 mode (bits [3:0] prescale, bit 9 polarity, bit 10 update target), 1 enable (bit 0), 2 period, 3 duty, 4 update, 5 status (bit 0 is the channel flag). Mode, enable, period, duty and status read back their current values, and the update address reads 0.
- R3: The period counter advances once every 2^prescale input clocks. A prescale write above 10 is saturated to 10.
- R4: Writing enable 1 to a stopped channel restarts the counter at 0. The counter then counts 0 to period-1 and wraps. The output is inactive while count < duty and active otherwise, so a duty value at or above the period keeps the output inactive for the whole period.
- R5: While the channel is disabled the output holds the inactive level, and writes to period and duty take effect at once.
- R6: While the channel is enabled, direct writes to period and duty are ignored. A mode write changes only the update target bit, and prescale and polarity keep their values.
- R7: A write to the update register while the channel is enabled is held pending. At the next counter wrap it is copied into the duty value (target bit 0) or the period value (target bit 1), using the target bit as it was when the write occurred. A second write before the wrap replaces the first.
- R8: When a pending value is transferred, status bit 0 is set. A read of the status address returns the flag and clears it. If a transfer and a status read fall in the same cycle, the set wins. The flag stays 0 when no transfer happens.
- R9: Update writes while the channel is disabled are ignored. Disabling the channel discards any pending value, which is then never transferred and never raises the flag.
- R10: With polarity 1 the active level is 1 and the inactive level is 0. With polarity 0 both levels are inverted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears status on the status address) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data, valid in the same cycle as bus_rd |
| pwm_out | output | 1 | Modulated output |

## Verification
The hardest conditions to reach are those that depend on where the counter stands when software acts. Examples are an update written mid-period, replaced by a second write, or dropped by a disable before the wrap. The bench keeps its own cycle-accurate picture of the prescaler, the counter and the pending value, built from the requirements. It steps the clock until that picture shows a chosen count, then issues the bus operation at that cycle. Because of this, the point where the new duty or period should appear is known exactly. It is checked sample by sample on the output and then confirmed through read-back and the status flag.

// File: rtl/pwm_buf_pkg.sv
package pwm_buf_pkg;

    localparam int PRES_W   = 4;
    localparam int PRES_MAX = 10;
    localparam int DIV_W    = PRES_MAX;
    localparam int POL_BIT  = 9;
    localparam int TGT_BIT  = 10;
    localparam int ADDR_W   = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_MODE   = 3'd0,
        REG_ENABLE = 3'd1,
        REG_PERIOD = 3'd2,
        REG_DUTY   = 3'd3,
        REG_UPDATE = 3'd4,
        REG_STATUS = 3'd5
    } reg_addr_e;

    typedef enum logic {
        UPD_DUTY   = 1'b0,
        UPD_PERIOD = 1'b1
    } upd_tgt_e;

    typedef struct packed {
        logic [PRES_W-1:0] pres;
        logic              pol;
        upd_tgt_e          tgt;
    } mode_t;

    // Clamp an out-of-range prescale setting to the largest legal one.
    function automatic logic [PRES_W-1:0] sat_pres(input logic [PRES_W-1:0] v);
        return (v > PRES_W'(PRES_MAX)) ? PRES_W'(PRES_MAX) : v;
    endfunction

    // Terminal count of the prescale divider: 2^pres - 1.
    function automatic logic [DIV_W-1:0] pres_mask(input logic [PRES_W-1:0] p);
        return (DIV_W'(1) << p) - DIV_W'(1);
    endfunction

    // Map an active/inactive state onto the pin level.
    function automatic logic pin_level(input logic active, input logic pol);
        return pol ? active : ~active;
    endfunction

endpackage

// File: rtl/pwm_buf_regs.sv
module pwm_buf_regs
    import pwm_buf_pkg::*;
#(
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic              wrap,
    output mode_t             mode,
    output logic              en,
    output logic [CW-1:0]     period,
    output logic [CW-1:0]     duty,
    output logic              restart,
    output logic              upd_done
);

    logic           upd_pend;
    logic [CW-1:0]  upd_val;
    upd_tgt_e       upd_tgt;

    logic wr_mode, wr_enable, wr_period, wr_duty, wr_update, rd_status;

    assign wr_mode   = bus_wr && (bus_addr == REG_MODE);
    assign wr_enable = bus_wr && (bus_addr == REG_ENABLE);
    assign wr_period = bus_wr && (bus_addr == REG_PERIOD);
    assign wr_duty   = bus_wr && (bus_addr == REG_DUTY);
    assign wr_update = bus_wr && (bus_addr == REG_UPDATE);
    assign rd_status = bus_rd && (bus_addr == REG_STATUS);

    assign restart = wr_enable && bus_wdata[0] && !en;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode     <= '{pres: '0, pol: 1'b1, tgt: UPD_DUTY};
            en       <= 1'b0;
            period   <= '0;
            duty     <= '0;
            upd_pend <= 1'b0;
            upd_val  <= '0;
            upd_tgt  <= UPD_DUTY;
            upd_done <= 1'b0;
        end else begin
            // Mode: only the update target may change while running.
            if (wr_mode) begin
                mode.tgt <= upd_tgt_e'(bus_wdata[TGT_BIT]);
                if (!en) begin
                    mode.pres <= sat_pres(bus_wdata[PRES_W-1:0]);
                    mode.pol  <= bus_wdata[POL_BIT];
                end
            end

            if (wr_enable) begin
                en <= bus_wdata[0];
                if (!bus_wdata[0]) upd_pend <= 1'b0;
            end

            // Direct access only while stopped.
            if (wr_period && !en) period <= bus_wdata[CW-1:0];
            if (wr_duty   && !en) duty   <= bus_wdata[CW-1:0];

            if (rd_status) upd_done <= 1'b0;

            // Transfer at the period boundary; the set wins over a clearing read.
            if (wrap && upd_pend) begin
                upd_pend <= 1'b0;
                upd_done <= 1'b1;
                if (upd_tgt == UPD_PERIOD) period <= upd_val;
                else                       duty   <= upd_val;
            end

            // A new write (even on a wrap cycle) becomes the next pending value.
            if (wr_update && en && !(wr_enable && !bus_wdata[0])) begin
                upd_pend <= 1'b1;
                upd_val  <= bus_wdata[CW-1:0];
                upd_tgt  <= mode.tgt;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            REG_MODE: begin
                bus_rdata[PRES_W-1:0] = mode.pres;
                bus_rdata[POL_BIT]    = mode.pol;
                bus_rdata[TGT_BIT]    = mode.tgt;
            end
            REG_ENABLE: bus_rdata[0]      = en;
            REG_PERIOD: bus_rdata[CW-1:0] = period;
            REG_DUTY:   bus_rdata[CW-1:0] = duty;
            REG_STATUS: bus_rdata[0]      = upd_done;
            default:    bus_rdata         = '0;
        endcase
    end

    logic unused_wdata_bits;
    assign unused_wdata_bits = ^bus_wdata;

endmodule

// File: rtl/pwm_buf_prescaler.sv
module pwm_buf_prescaler
    import pwm_buf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              restart,
    input  logic [PRES_W-1:0] pres,
    output logic              tick
);

    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] term;

    assign term = pres_mask(pres);
    assign tick = en && (div_cnt == term);

    always_ff @(posedge clk) begin
        if (rst || restart || !en) begin
            div_cnt <= '0;
        end else if (tick) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + DIV_W'(1);
        end
    end

endmodule

// File: rtl/pwm_buf_wave.sv
module pwm_buf_wave
    import pwm_buf_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          restart,
    input  logic          tick,
    input  logic [CW-1:0] period,
    input  logic [CW-1:0] duty,
    input  logic          pol,
    output logic [CW-1:0] cnt,
    output logic          wrap,
    output logic          pwm_out
);

    logic [CW:0] cnt_inc;
    logic        active;

    assign cnt_inc = {1'b0, cnt} + (CW+1)'(1);
    assign wrap    = en && tick && (cnt_inc >= {1'b0, period});

    always_ff @(posedge clk) begin
        if (rst || restart || !en) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= wrap ? '0 : cnt_inc[CW-1:0];
        end
    end

    assign active  = en && (cnt >= duty);
    assign pwm_out = pin_level(active, pol);

endmodule

// File: rtl/pwm_buf_chan.sv
module pwm_buf_chan
    import pwm_buf_pkg::*;
#(
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              pwm_out
);

    mode_t          mode_q;
    logic           en_q;
    logic [CW-1:0]  period_q;
    logic [CW-1:0]  duty_q;
    logic           restart_w;
    logic           done_q;
    logic           tick_w;
    logic           wrap_w;
    logic [CW-1:0]  cnt_q;

    pwm_buf_regs #(.DW(DW), .CW(CW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .wrap      (wrap_w),
        .mode      (mode_q),
        .en        (en_q),
        .period    (period_q),
        .duty      (duty_q),
        .restart   (restart_w),
        .upd_done  (done_q)
    );

    pwm_buf_prescaler u_pres (
        .clk     (clk),
        .rst     (rst),
        .en      (en_q),
        .restart (restart_w),
        .pres    (mode_q.pres),
        .tick    (tick_w)
    );

    pwm_buf_wave #(.CW(CW)) u_wave (
        .clk     (clk),
        .rst     (rst),
        .en      (en_q),
        .restart (restart_w),
        .tick    (tick_w),
        .period  (period_q),
        .duty    (duty_q),
        .pol     (mode_q.pol),
        .cnt     (cnt_q),
        .wrap    (wrap_w),
        .pwm_out (pwm_out)
    );

endmodule

// File: rtl/pwm_buf_chan_chk.sv
module pwm_buf_chan_chk
    import pwm_buf_pkg::*;
#(
    parameter int CW = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic              pol,
    input logic [PRES_W-1:0] pres,
    input logic [CW-1:0]     period,
    input logic [CW-1:0]     duty,
    input logic [CW-1:0]     cnt,
    input logic              wrap,
    input logic              flag,
    input logic              pwm_out
);

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
        !en |-> (pwm_out == !pol)); // R5

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (en && period != '0) |-> (cnt < period)); // R4

    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
        $rose(en) |-> (cnt == '0)); // R4

    AST_PRES_SAT: assert property (@(posedge clk) disable iff (rst)
        pres <= PRES_W'(PRES_MAX)); // R3

    AST_FLAG_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(wrap)); // R8

    AST_VALUES_HELD: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && !$past(wrap)) |-> ($stable(period) && $stable(duty))); // R6

    AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en)) |-> ($stable(pol) && $stable(pres))); // R6

endmodule

bind pwm_buf_chan pwm_buf_chan_chk #(.CW(CW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .en      (en_q),
    .pol     (mode_q.pol),
    .pres    (mode_q.pres),
    .period  (period_q),
    .duty    (duty_q),
    .cnt     (cnt_q),
    .wrap    (wrap_w),
    .flag    (done_q),
    .pwm_out (pwm_out)
);

// File: tb/pwm_buf_chan_tb.sv
module pwm_buf_chan_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        pwm_out;

    int n_checks = 0;
    int n_fail   = 0;

    // Behavioural picture of the channel, built from the requirements.
    int m_en = 0, m_pol = 1, m_pres = 0, m_tgt = 0;
    int m_prd = 0, m_dty = 0, m_cnt = 0, m_ps = 0;
    int m_pend = 0, m_pval = 0, m_ptgt = 0, m_flag = 0;

    localparam logic [2:0] A_MODE = 3'd0, A_EN = 3'd1, A_PRD = 3'd2,
                           A_DTY = 3'd3, A_UPD = 3'd4, A_STAT = 3'd5;

    always #5 clk = ~clk;

    pwm_buf_chan u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock edge, model advanced to match.
    task automatic adv();
        @(negedge clk);
        if (m_en != 0) begin
            if (m_ps == (1 << m_pres) - 1) begin
                m_ps = 0;
                if (m_cnt + 1 >= m_prd) begin
                    m_cnt = 0;
                    if (m_pend != 0) begin
                        m_pend = 0;
                        m_flag = 1;
                        if (m_ptgt != 0) m_prd = m_pval;
                        else             m_dty = m_pval;
                    end
                end else begin
                    m_cnt++;
                end
            end else begin
                m_ps++;
            end
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        int was_en;
        int was_tgt;
        was_en  = m_en;
        was_tgt = m_tgt;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        adv();
        bus_wr = 1'b0;
        case (a)
            A_MODE: begin
                m_tgt = int'(d[10]);
                if (was_en == 0) begin
                    m_pres = (d[3:0] > 4'd10) ? 10 : int'(d[3:0]);
                    m_pol  = int'(d[9]);
                end
            end
            A_EN: begin
                if (d[0] && was_en == 0) begin
                    m_en = 1; m_cnt = 0; m_ps = 0;
                end else if (!d[0]) begin
                    m_en = 0; m_pend = 0; m_cnt = 0; m_ps = 0;
                end
            end
            A_PRD: if (was_en == 0) m_prd = int'(d[15:0]);
            A_DTY: if (was_en == 0) m_dty = int'(d[15:0]);
            A_UPD: if (was_en != 0) begin
                m_pend = 1; m_pval = int'(d[15:0]); m_ptgt = was_tgt;
            end
            default: ;
        endcase
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #2;
        d = bus_rdata;
        if (a == A_STAT) m_flag = 0;
        adv();
        bus_rd = 1'b0;
    endtask

    task automatic chk_rd(input string tag, input logic [2:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic chk_out(input string tag);
        int act_lvl;
        act_lvl = (m_en != 0 && m_cnt >= m_dty) ? 1 : 0;
        chk(tag, {31'd0, pwm_out}, (m_pol != 0) ? act_lvl : 1 - act_lvl);
    endtask

    task automatic run(input string tag, input int n);
        for (int i = 0; i < n; i++) begin
            adv();
            chk_out(tag);
        end
    endtask

    task automatic go_to_count(input int c);
        for (int i = 0; i < 200 && m_cnt != c; i++) adv();
    endtask

    task automatic t_reset();
        chk("R1 idle output", {31'd0, pwm_out}, 32'd0);
        chk_rd("R1 mode reset", A_MODE, 32'h200);
        chk_rd("R1 period reset", A_PRD, 32'd0);
        chk_rd("R1 duty reset", A_DTY, 32'd0);
        chk_rd("R1 enable reset", A_EN, 32'd0);
        chk_rd("R1 status reset", A_STAT, 32'd0);
        chk_rd("R2 update address reads 0", A_UPD, 32'd0);
    endtask

    task automatic t_basic();
        wr(A_PRD, 32'd10);
        wr(A_DTY, 32'd4);
        chk_rd("R5 direct period write", A_PRD, 32'd10);
        chk_rd("R5 direct duty write", A_DTY, 32'd4);
        chk_out("R5 inactive while stopped");
        wr(A_EN, 32'd1);
        chk_rd("R2 enable readback", A_EN, 32'd1);
        run("R4 waveform 10/4", 25);
        wr(A_EN, 32'd0);
        chk_out("R5 inactive after disable");
    endtask

    task automatic t_duty_ge();
        wr(A_DTY, 32'd10);
        wr(A_EN, 32'd1);
        run("R4 duty equal period", 22);
        wr(A_EN, 32'd0);
        wr(A_DTY, 32'd15);
        wr(A_EN, 32'd1);
        run("R4 duty above period", 22);
        wr(A_EN, 32'd0);
    endtask

    task automatic t_polarity();
        wr(A_MODE, 32'h000);
        chk("R10 inverted idle level", {31'd0, pwm_out}, 32'd1);
        wr(A_PRD, 32'd6);
        wr(A_DTY, 32'd2);
        wr(A_EN, 32'd1);
        run("R10 inverted waveform", 14);
        wr(A_EN, 32'd0);
        wr(A_MODE, 32'h200);
        chk("R10 normal idle level", {31'd0, pwm_out}, 32'd0);
    endtask

    task automatic t_prescale();
        wr(A_MODE, 32'h20F);
        chk_rd("R3 prescale saturates", A_MODE, 32'h20A);
        wr(A_MODE, 32'h202);
        wr(A_PRD, 32'd4);
        wr(A_DTY, 32'd1);
        wr(A_EN, 32'd1);
        run("R3 divide by 4", 40);
        wr(A_EN, 32'd0);
        wr(A_MODE, 32'h200);
    endtask

    task automatic t_locked();
        wr(A_PRD, 32'd8);
        wr(A_DTY, 32'd3);
        wr(A_EN, 32'd1);
        run("R4 waveform 8/3", 5);
        wr(A_PRD, 32'd20);
        wr(A_DTY, 32'd1);
        chk_rd("R6 period write ignored", A_PRD, 32'd8);
        chk_rd("R6 duty write ignored", A_DTY, 32'd3);
        wr(A_MODE, 32'h405);
        chk_rd("R6 only target bit changes", A_MODE, 32'h600);
        run("R6 waveform unchanged", 16);
        wr(A_EN, 32'd0);
        wr(A_MODE, 32'h200);
    endtask

    task automatic t_upd_duty();
        wr(A_PRD, 32'd10);
        wr(A_DTY, 32'd2);
        wr(A_EN, 32'd1);
        go_to_count(3);
        wr(A_UPD, 32'd7);
        chk_rd("R8 no flag before wrap", A_STAT, 32'd0);
        chk_rd("R7 duty held until wrap", A_DTY, 32'd2);
        run("R7 duty switches at wrap", 20);
        chk_rd("R7 duty transferred", A_DTY, 32'd7);
        chk_rd("R8 flag after transfer", A_STAT, 32'd1);
        chk_rd("R8 flag cleared by read", A_STAT, 32'd0);
    endtask

    task automatic t_upd_period();
        wr(A_MODE, 32'h600);
        go_to_count(2);
        wr(A_UPD, 32'd9);
        wr(A_UPD, 32'd12);
        chk_rd("R7 period held until wrap", A_PRD, 32'd10);
        run("R7 period switches at wrap", 30);
        chk_rd("R7 last write wins", A_PRD, 32'd12);
        chk_rd("R7 duty untouched", A_DTY, 32'd7);
        chk_rd("R8 flag after period transfer", A_STAT, 32'd1);
        run("R8 quiet run", 30);
        chk_rd("R8 no flag without update", A_STAT, 32'd0);
    endtask

    task automatic t_disabled_upd();
        wr(A_EN, 32'd0);
        wr(A_UPD, 32'd3);
        chk_rd("R9 period unchanged by stopped update", A_PRD, 32'd12);
        chk_rd("R9 duty unchanged by stopped update", A_DTY, 32'd7);
        wr(A_EN, 32'd1);
        run("R9 waveform after stopped update", 26);
        chk_rd("R9 no flag from stopped update", A_STAT, 32'd0);
        go_to_count(1);
        wr(A_UPD, 32'd5);
        wr(A_EN, 32'd0);
        wr(A_EN, 32'd1);
        run("R9 pending dropped", 30);
        chk_rd("R9 dropped value never applied", A_PRD, 32'd12);
        chk_rd("R9 no flag from dropped value", A_STAT, 32'd0);
        wr(A_EN, 32'd0);
    endtask

    initial begin : watchdog
        #(200000 * 10);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_duty_ge();
        t_polarity();
        t_prescale();
        t_locked();
        t_upd_duty();
        t_upd_period();
        t_disabled_upd();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule